// File: doc/BRIEF.md
# DMA Multimode Address Generator

This block produces the byte address sequence for one side of a DMA block transfer, either the read side or the write side. A transfer is a number of frames, each holding the same number of elements. An element is 1, 2 or 4 bytes wide, so the transfer moves frames × elements × element-size bytes. A start pulse captures the whole configuration: the first address, the stepping mode, the element size, the two signed index offsets and both counts. The block then offers one address per valid/ready handshake until the last element of the last frame has been accepted.

The block keeps a pointer to the current element. To step, it takes the top byte of that element and adds an offset. In constant mode the offset returns to the same element. In post-increment mode the offset is one byte. Single-index mode always adds the element index. Double-index mode adds the element index inside a frame and the frame index after the last element of a frame. Each offered address carries end-of-frame and end-of-block flags. Any address that is not a multiple of the element size halts the block with an error until the next start. Bus access and data movement belong to other blocks.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `done` and `err` are low.
- R2: A `start` pulse captures all `cfg_*` inputs. From the next clock edge, `addr` shows `cfg_base` with `addr_valid` high, provided the base is aligned. The element size code `cfg_esz` selects 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes. A `start` also clears `done` and `err`.
- R3: With `cfg_mode` = 0 (constant), every offered address equals the base.
- R4: With `cfg_mode` = 1 (post-increment), each accepted address is followed by that address plus the element size, including across frame boundaries.
- R5: With `cfg_mode` = 2 (single-index), each next address is the previous address + size − 1 + EI, including across frames. EI is `cfg_eidx`, a 16-bit two's-complement value that is sign-extended.
- R6: With `cfg_mode` = 3 (double-index), the step inside a frame is size − 1 + EI. After the last element of a frame the step is size − 1 + FI, where FI is `cfg_fidx`, also signed. With EI = FI = 1 the sequence matches post-increment.
- R7: An address that is not a multiple of the element size is never offered, and this includes the base. One cycle after such an address is reached, `err` rises and stays high, while `addr_valid` stays low regardless of `addr_ready`, until the next `start`.
- R8: `frame_last` is high with the last element of every frame. `block_last` is high only with the last element of the last frame, and it implies `frame_last`.
- R9: After the block-last address is accepted, `done` rises on the next edge and `addr_valid` stays low. Further `addr_ready` has no effect until a new `start`.
- R10: While `addr_valid` is high and `addr_ready` is low, `addr` and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures the configuration and begins a block |
| cfg_base | input | 32 | First element address |
| cfg_mode | input | 2 | Stepping mode: 0 constant, 1 post-increment, 2 single-index, 3 double-index |
| cfg_esz | input | 2 | Element size code |
| cfg_eidx | input | 16 | Signed element index |
| cfg_fidx | input | 16 | Signed frame index |
| cfg_elems | input | 16 | Elements per frame |
| cfg_frames | input | 16 | Frames per block |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_valid | output | 1 | `addr` holds an element address |
| addr | output | 32 | Current element address |
| frame_last | output | 1 | Offered element ends a frame |
| block_last | output | 1 | Offered element ends the block |
| done | output | 1 | Block completed |
| err | output | 1 | Halted on a misaligned address |

## Verification
On every cycle, the assertions check that offered addresses are aligned and that the address holds while stalled. They also check the constant and post-increment steps, that an error or completion state offers nothing, and that `done` and `err` are entered only through their causing events. The signed index arithmetic of the single-index and double-index modes, the frame-boundary switch to FI, and the exact position of the frame and block flags in the sequence are shown only by the bench's scenarios. These scenarios compare whole address sequences against a model that tracks the top byte of each element.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INCR  = 2'd1,
    AM_SIDX  = 2'd2,
    AM_DIDX  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_HALT = 2'd3
  } agst_e;

  // element size code to byte count
  function automatic logic [2:0] es_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/agen_count.sv
module agen_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  // a limit of zero wraps to the full 2**W range
  assign at_last = (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (adv)    cnt <= at_last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/agen_step.sv
module agen_step
  import dma_ag_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic [AW-1:0] cur,
  input  amode_e        mode,
  input  logic [2:0]    esb,
  input  logic [IW-1:0] eidx,
  input  logic [IW-1:0] fidx,
  input  logic          frame_end,
  output logic [AW-1:0] nxt
);
  localparam int PADW = AW - IW;

  function automatic logic [AW-1:0] sext(input logic [IW-1:0] v);
    return {{PADW{v[IW-1]}}, v};
  endfunction

  // pointer rests on the top byte of the element just accessed
  function automatic logic [AW-1:0] step_from(
    input logic [AW-1:0] a, input amode_e m, input logic [2:0] sz,
    input logic [IW-1:0] ei, input logic [IW-1:0] fi, input logic fe);
    logic [AW-1:0] top;
    top = a + AW'(sz) - AW'(1);
    case (m)
      AM_FIXED: return a;
      AM_INCR:  return top + AW'(1);
      AM_SIDX:  return top + sext(ei);
      default:  return top + sext(fe ? fi : ei);
    endcase
  endfunction

  assign nxt = step_from(cur, mode, esb, eidx, fidx, frame_end);
endmodule

// File: rtl/agen_align.sv
module agen_align #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    esb,
  output logic          misaligned
);
  logic [1:0] low_mask;
  assign low_mask   = esb[1:0] - 2'd1 | {esb[2], esb[2]};
  assign misaligned = |(cur[1:0] & low_mask);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_base,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_esz,
  input  logic [IW-1:0] cfg_eidx,
  input  logic [IW-1:0] cfg_fidx,
  input  logic [CW-1:0] cfg_elems,
  input  logic [CW-1:0] cfg_frames,
  input  logic          addr_ready,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          frame_last,
  output logic          block_last,
  output logic          done,
  output logic          err
);
  agst_e         st;
  amode_e        mode_q;
  logic [1:0]    esz_q;
  logic [IW-1:0] eidx_q, fidx_q;
  logic [CW-1:0] elems_q, frames_q;
  logic [AW-1:0] cur, nxt;

  // named internal events
  logic [2:0]    esb;
  logic          misaligned;
  logic          xfer;
  logic          frame_end;
  logic          last_frame;
  logic          block_end;
  logic [CW-1:0] elem_cnt, frame_cnt;

  assign esb = es_bytes(esz_q);

  agen_align #(.AW(AW)) u_align (
    .cur(cur), .esb(esb), .misaligned(misaligned)
  );

  agen_step #(.AW(AW), .IW(IW)) u_step (
    .cur(cur), .mode(mode_q), .esb(esb), .eidx(eidx_q), .fidx(fidx_q),
    .frame_end(frame_end), .nxt(nxt)
  );

  agen_count #(.W(CW)) u_elem_cnt (
    .clk(clk), .rst_n(rst_n), .clear(start), .adv(xfer),
    .limit(elems_q), .cnt(elem_cnt), .at_last(frame_end)
  );

  agen_count #(.W(CW)) u_frame_cnt (
    .clk(clk), .rst_n(rst_n), .clear(start), .adv(xfer & frame_end),
    .limit(frames_q), .cnt(frame_cnt), .at_last(last_frame)
  );

  assign block_end  = frame_end & last_frame;
  assign addr_valid = (st == ST_RUN) & ~misaligned;
  assign xfer       = addr_valid & addr_ready & ~start;
  assign addr       = cur;
  assign frame_last = addr_valid & frame_end;
  assign block_last = addr_valid & block_end;
  assign done       = (st == ST_DONE);
  assign err        = (st == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur      <= '0;
      mode_q   <= AM_FIXED;
      esz_q    <= '0;
      eidx_q   <= '0;
      fidx_q   <= '0;
      elems_q  <= '0;
      frames_q <= '0;
    end else if (start) begin
      st       <= ST_RUN;
      cur      <= cfg_base;
      mode_q   <= amode_e'(cfg_mode);
      esz_q    <= cfg_esz;
      eidx_q   <= cfg_eidx;
      fidx_q   <= cfg_fidx;
      elems_q  <= cfg_elems;
      frames_q <= cfg_frames;
    end else if (st == ST_RUN) begin
      if (misaligned)     st  <= ST_HALT;
      else if (xfer) begin
        if (block_end)    st  <= ST_DONE;
        else              cur <= nxt;
      end
    end
  end
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          addr_ready,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          frame_last,
  input logic          block_last,
  input logic          done,
  input logic          err,
  input logic          xfer,
  input logic          misaligned,
  input logic          block_end,
  input logic [2:0]    esb,
  input logic [1:0]    mode_q
);
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> ((addr % AW'(esb)) == '0));

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!addr_valid && !done));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(misaligned && !start));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !start) |=> (addr_valid && $stable(addr)));

  assert_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !block_end && mode_q == 2'd0) |=> (start || addr == $past(addr)));

  assert_incr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !block_end && mode_q == 2'd1) |=>
      (start || addr == $past(addr) + AW'($past(esb))));

  assert_eob_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    block_last |-> frame_last);

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xfer && block_end));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .addr_ready(addr_ready),
  .addr_valid(addr_valid), .addr(addr), .frame_last(frame_last),
  .block_last(block_last), .done(done), .err(err), .xfer(xfer),
  .misaligned(misaligned), .block_end(block_end), .esb(esb),
  .mode_q(mode_q)
);

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
  typedef struct packed {
    logic [31:0] base;
    logic [1:0]  mode;
    logic [1:0]  esz;
    logic [15:0] ei;
    logic [15:0] fi;
    logic [15:0] en;
    logic [15:0] fn;
  } vec_t;

  // base, mode, esz, EI, FI, elements, frames
  localparam vec_t VT [7] = '{
    '{32'h0000_1000, 2'd0, 2'd2, 16'd0,     16'd0,     16'd3, 16'd2}, // R3
    '{32'h0000_2000, 2'd1, 2'd1, 16'd0,     16'd0,     16'd3, 16'd2}, // R4
    '{32'h0000_3000, 2'd2, 2'd2, 16'd5,     16'd0,     16'd3, 16'd2}, // R5
    '{32'h0000_4010, 2'd3, 2'd1, 16'd3,     16'hFFF9,  16'd2, 16'd3}, // R6
    '{32'h0000_5003, 2'd3, 2'd0, 16'd1,     16'd1,     16'd2, 16'd2}, // R6 eq
    '{32'h0000_6010, 2'd2, 2'd2, 16'hFFF9,  16'd0,     16'd4, 16'd1}, // R5 neg
    '{32'h0000_7000, 2'd3, 2'd3, 16'd1,     16'd1,     16'd2, 16'd2}  // R6 eq
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [1:0]  cfg_mode = '0;
  logic [1:0]  cfg_esz = '0;
  logic [15:0] cfg_eidx = '0;
  logic [15:0] cfg_fidx = '0;
  logic [15:0] cfg_elems = '0;
  logic [15:0] cfg_frames = '0;
  logic        addr_ready = 1'b0;
  logic        addr_valid, frame_last, block_last, done, err;
  logic [31:0] addr;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dma_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_mode(cfg_mode), .cfg_esz(cfg_esz), .cfg_eidx(cfg_eidx),
    .cfg_fidx(cfg_fidx), .cfg_elems(cfg_elems), .cfg_frames(cfg_frames),
    .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr),
    .frame_last(frame_last), .block_last(block_last), .done(done), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_err = n_err + 1;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic kick(input vec_t v);
    @(negedge clk);
    start = 1'b1;
    cfg_base = v.base; cfg_mode = v.mode; cfg_esz = v.esz;
    cfg_eidx = v.ei; cfg_fidx = v.fi; cfg_elems = v.en; cfg_frames = v.fn;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic int bytes_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  // walk a full block with ready held high; model tracks the top byte
  task automatic run_vec(input vec_t v, input string req);
    logic [31:0] exp_a;
    logic [31:0] top;
    int sz;
    sz = bytes_of(v.esz);
    exp_a = v.base;
    kick(v);
    addr_ready = 1'b1;
    for (int f = 0; f < int'(v.fn); f++) begin
      for (int e = 0; e < int'(v.en); e++) begin
        bit fl, bl;
        fl = (e == int'(v.en) - 1);
        bl = fl && (f == int'(v.fn) - 1);
        chk(addr_valid && addr == exp_a, req, "addr", addr, exp_a);
        chk(frame_last == fl && block_last == bl, "R8", "flags",
            {30'd0, frame_last, block_last}, {30'd0, fl, bl});
        top = exp_a + 32'(sz - 1);
        case (v.mode)
          2'd0: exp_a = exp_a;
          2'd1: exp_a = top + 32'd1;
          2'd2: exp_a = top + 32'($signed(v.ei));
          default: exp_a = top + (fl ? 32'($signed(v.fi)) : 32'($signed(v.ei)));
        endcase
        @(negedge clk);
      end
    end
    chk(done && !addr_valid, "R9", "done after block",
        {30'd0, done, addr_valid}, 32'h2);
    @(negedge clk);
    @(negedge clk);
    chk(done && !addr_valid, "R9", "ready ignored when done",
        {30'd0, done, addr_valid}, 32'h2);
    addr_ready = 1'b0;
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk(!addr_valid && !done && !err, "R1", "reset outputs",
        {29'd0, addr_valid, done, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R2..R6, R8, R9
    run_vec(VT[0], "R3");
    run_vec(VT[1], "R4");
    run_vec(VT[2], "R5");
    run_vec(VT[3], "R6");
    run_vec(VT[4], "R6");
    run_vec(VT[5], "R5");
    run_vec(VT[6], "R6");

    // R2: restart clears done and presents the base
    v = '{32'h0000_0800, 2'd1, 2'd0, 16'd0, 16'd0, 16'd4, 16'd1};
    kick(v);
    chk(addr_valid && addr == 32'h800 && !done, "R2", "start presents base",
        addr, 32'h800);

    // R10: stall holds address and flags
    repeat (3) begin
      @(negedge clk);
      chk(addr_valid && addr == 32'h800 && !frame_last, "R10", "stall hold",
          addr, 32'h800);
    end
    addr_ready = 1'b1;
    @(negedge clk);
    addr_ready = 1'b0;
    chk(addr_valid && addr == 32'h801, "R4", "step after stall", addr, 32'h801);

    // R7: misaligned base (2-byte elements at odd address)
    v = '{32'h0000_0201, 2'd1, 2'd1, 16'd0, 16'd0, 16'd4, 16'd1};
    kick(v);
    addr_ready = 1'b1;
    chk(!addr_valid, "R7", "misaligned base not offered",
        {31'd0, addr_valid}, 32'h0);
    @(negedge clk);
    chk(err && !addr_valid, "R7", "err after misaligned base",
        {30'd0, err, addr_valid}, 32'h2);
    repeat (3) @(negedge clk);
    chk(err && !addr_valid && !done, "R7", "halt persists",
        {29'd0, err, addr_valid, done}, 32'h4);
    addr_ready = 1'b0;

    // R7: misaligned mid-block (4-byte, EI=3 -> step of 6)
    v = '{32'h0000_0100, 2'd2, 2'd2, 16'd3, 16'd0, 16'd4, 16'd1};
    kick(v);
    chk(addr_valid && addr == 32'h100 && !err, "R2", "restart clears err",
        addr, 32'h100);
    addr_ready = 1'b1;
    @(negedge clk);
    chk(!addr_valid, "R7", "misaligned step not offered",
        {31'd0, addr_valid}, 32'h0);
    @(negedge clk);
    chk(err, "R7", "err after misaligned step", {31'd0, err}, 32'h1);
    addr_ready = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule